// File: doc/BRIEF.md
# Two-Channel PLL Lock Monitor

This block decides whether each of two phase-locked loops has settled. It uses the reference pulse and the divided feedback pulse of each loop, both already synchronous to a fast sampling clock. On every comparison cycle it measures the distance between the two rising edges, counted in fast-clock ticks. It then qualifies that distance against a tick threshold.

Declaring lock is deliberately slow and losing it is deliberately quick. A run of consecutive tight comparisons is needed before the flag goes high. Once the flag is high, the acceptance window doubles, and a single comparison beyond the wider window clears the flag.

The two channels differ only in their thresholds and in one extra option. The first channel (the high-frequency loop) can evaluate only every fourth comparison, for use at high comparison rates. A view select picks which channel drives the single output pin. The select can also pick a combined view that is high only while both loops are locked.

A power-down input per channel holds that channel in its initial state and forces its view low. A re-initialise strobe, raised when the loop's divider is rewritten, restarts qualification on both channels.

Top module: `pll_lock_monitor`

## Requirements
- R1: A channel's lock flag rises only after RUN_LEN (default 5) consecutive evaluated comparisons whose edge gap is strictly below the channel's acquire threshold. The flag is visible on the clock edge that evaluates the last of them.
- R2: While locked, a comparison with a gap up to and including the hold threshold (twice the acquire threshold) keeps lock. One evaluated comparison with a larger gap, or with no paired edge, clears lock and the run count.
- R3: The default acquire/hold thresholds are 10/20 ticks for the first channel and 15/30 ticks for the second channel.
- R4: While unlocked, an evaluated comparison whose gap is at or above the acquire threshold, or which is unpaired, resets the run of good comparisons to zero.
- R5: A second reference edge arriving before the feedback edge ends the pending comparison as a failure. The new reference edge then opens the next comparison.
- R6: With rf_div4_i high, the first channel evaluates only the 4th, 8th, 12th, … comparison event counted since the option was enabled (or since re-initialise or power-down). The other events have no effect. The second channel ignores this input.
- R7: While a channel's power-down input is high, that channel's view is low. Its run count, lock flag, event prescaler and pending measurement are cleared.
- R8: view_i selects the output. 0 shows the first channel, 1 shows the second channel, and 2 or 3 shows the AND of both channels. The combined view is low whenever either channel is unlocked or powered down.
- R9: A one-cycle reinit_i pulse clears lock, the run count, the prescaler and any pending measurement on both channels.
- R10: The gap is measured the same way whichever edge arrives first. Edges seen in the same clock cycle give a gap of 0.
- R11: After reset, lock_o is low in every view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_ref_i | input | 1 | First-channel reference pulse |
| rf_fb_i | input | 1 | First-channel divided feedback pulse |
| if_ref_i | input | 1 | Second-channel reference pulse |
| if_fb_i | input | 1 | Second-channel divided feedback pulse |
| rf_pd_i | input | 1 | First-channel power-down |
| if_pd_i | input | 1 | Second-channel power-down |
| rf_div4_i | input | 1 | Evaluate only every fourth first-channel comparison |
| reinit_i | input | 1 | Re-initialise strobe, both channels |
| view_i | input | 2 | Output view select |
| lock_o | output | 1 | Selected lock indication |

## Verification
Stimulus is built from comparison periods. Each period drives, per channel, a reference pulse and an optional feedback pulse at a chosen offset, which may be positive, zero or negative. Gaps sitting exactly on the acquire and hold thresholds separate strict from inclusive comparisons, and the difference between the two channels' thresholds shows that each channel uses its own pair. Runs of four good periods versus five show the run length. A dropped feedback pulse confirms that a double reference counts as a failure. Long quarter-rate runs with bad gaps on the skipped events show that the prescaler ignores them, while seeded random gap sequences, combined with power-down and re-initialise, are checked against a model built from the requirements.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    parameter int unsigned GAP_W = 8;

    typedef logic [GAP_W-1:0] gap_t;

    typedef enum logic [1:0] {
        VIEW_RF   = 2'd0,
        VIEW_IF   = 2'd1,
        VIEW_BOTH = 2'd2,
        VIEW_ALT  = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_REF_1 = 2'd1,
        MS_FB_1  = 2'd2
    } meas_e;

    typedef enum logic {
        KIND_RF = 1'b0,
        KIND_IF = 1'b1
    } pll_kind_e;

    // One finished comparison: paired=0 means one edge never met its partner
    typedef struct packed {
        logic valid;
        logic paired;
        gap_t gap;
    } gap_ev_t;

    function automatic int unsigned acq_for(pll_kind_e kind, int unsigned rf_t, int unsigned if_t);
        return (kind == KIND_RF) ? rf_t : if_t;
    endfunction

    function automatic gap_t sat_inc(gap_t v);
        return (v == '1) ? v : v + gap_t'(1);
    endfunction

endpackage

// File: rtl/lockdet_gap_meter.sv
module lockdet_gap_meter
    import lockdet_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ref_i,
    input  logic    fb_i,
    output gap_ev_t ev_o
);

    logic  ref_q, fb_q;
    logic  ref_rise, fb_rise;
    meas_e st_q, st_d;
    gap_t  cnt_q, cnt_d;

    assign ref_rise = ref_i & ~ref_q;
    assign fb_rise  = fb_i  & ~fb_q;

    always_comb begin
        ev_o  = '0;
        st_d  = st_q;
        cnt_d = sat_inc(cnt_q);
        unique case (st_q)
            MS_IDLE: begin
                if (ref_rise && fb_rise) begin
                    ev_o = '{valid: 1'b1, paired: 1'b1, gap: '0};
                end else if (ref_rise) begin
                    st_d  = MS_REF_1;
                    cnt_d = gap_t'(1);
                end else if (fb_rise) begin
                    st_d  = MS_FB_1;
                    cnt_d = gap_t'(1);
                end
            end
            MS_REF_1: begin
                if (fb_rise) begin
                    ev_o = '{valid: 1'b1, paired: 1'b1, gap: cnt_q};
                    st_d = ref_rise ? MS_REF_1 : MS_IDLE;
                    cnt_d = gap_t'(1);
                end else if (ref_rise) begin
                    ev_o  = '{valid: 1'b1, paired: 1'b0, gap: cnt_q};
                    cnt_d = gap_t'(1);
                end
            end
            MS_FB_1: begin
                if (ref_rise) begin
                    ev_o = '{valid: 1'b1, paired: 1'b1, gap: cnt_q};
                    st_d = fb_rise ? MS_FB_1 : MS_IDLE;
                    cnt_d = gap_t'(1);
                end else if (fb_rise) begin
                    ev_o  = '{valid: 1'b1, paired: 1'b0, gap: cnt_q};
                    cnt_d = gap_t'(1);
                end
            end
            default: st_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            fb_q  <= 1'b0;
            st_q  <= MS_IDLE;
            cnt_q <= '0;
        end else begin
            ref_q <= ref_i;
            fb_q  <= fb_i;
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // R10: any gap reported while a first edge was pending is at least one tick
    p_pending_gap_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_o.valid && st_q != MS_IDLE) |-> (ev_o.gap != '0));

    // R5: a repeated reference while waiting for feedback keeps a window open
    p_double_ref_restarts_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == MS_REF_1 && ref_rise && !fb_rise) |=> (st_q == MS_REF_1 && cnt_q == gap_t'(1)));

endmodule

// File: rtl/lockdet_qualifier.sv
module lockdet_qualifier
    import lockdet_pkg::*;
#(
    parameter int unsigned ACQ_TICKS = 10,
    parameter int unsigned RUN_LEN   = 5,
    parameter bit          USE_DIV4  = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clear_i,
    input  logic    div4_i,
    input  gap_ev_t ev_i,
    output logic    lock_o
);

    localparam int unsigned HOLD_TICKS = 2 * ACQ_TICKS;
    localparam int unsigned RUN_W      = $clog2(RUN_LEN + 1);
    localparam gap_t        ACQ_G      = gap_t'(ACQ_TICKS);
    localparam gap_t        HOLD_G     = gap_t'(HOLD_TICKS);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

    logic             take;
    logic             good_acq;
    logic             bad_hold;
    logic             lock_q;
    logic [RUN_W-1:0] run_q;

    generate
        if (USE_DIV4) begin : g_div4
            logic [1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst || clear_i || !div4_i) begin
                    pre_q <= 2'd0;
                end else if (ev_i.valid) begin
                    pre_q <= pre_q + 2'd1;
                end
            end
            assign take = ev_i.valid && (!div4_i || pre_q == 2'd3);
        end else begin : g_every
            logic unused_div4;
            assign unused_div4 = div4_i;
            assign take = ev_i.valid;
        end
    endgenerate

    assign good_acq = ev_i.paired && (ev_i.gap < ACQ_G);
    assign bad_hold = !ev_i.paired || (ev_i.gap > HOLD_G);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            lock_q <= 1'b0;
            run_q  <= '0;
        end else if (take) begin
            if (lock_q) begin
                if (bad_hold) begin
                    lock_q <= 1'b0;
                    run_q  <= '0;
                end
            end else if (good_acq) begin
                if (run_q == RUN_LAST) begin
                    lock_q <= 1'b1;
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign lock_o = lock_q;

    // R1: lock can only appear on the edge that takes a tight comparison
    p_lock_needs_pass_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(take && good_acq && !clear_i));

    // R2: a wide or unpaired evaluated comparison while locked drops lock
    p_drop_on_wide_r2: assert property (@(posedge clk) disable iff (rst)
        (lock_q && take && bad_hold && !clear_i) |=> !lock_q);

    // R2: a comparison inside the hold window keeps lock
    p_keep_in_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (lock_q && take && ev_i.paired && ev_i.gap <= HOLD_G && !clear_i) |=> lock_q);

    // R4: a failing comparison while unlocked empties the run
    p_fail_resets_run_r4: assert property (@(posedge clk) disable iff (rst)
        (!lock_q && take && !good_acq && !clear_i) |=> (run_q == '0 && !lock_q));

    // R9: re-initialise leaves an empty, unlocked channel
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (!lock_q && run_q == '0));

endmodule

// File: rtl/lockdet_channel.sv
module lockdet_channel
    import lockdet_pkg::*;
#(
    parameter pll_kind_e   KIND         = KIND_RF,
    parameter int unsigned RF_ACQ_TICKS = 10,
    parameter int unsigned IF_ACQ_TICKS = 15,
    parameter int unsigned RUN_LEN      = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_i,
    input  logic clear_i,
    input  logic div4_i,
    input  logic ref_i,
    input  logic fb_i,
    output logic lock_o
);

    localparam int unsigned ACQ = acq_for(KIND, RF_ACQ_TICKS, IF_ACQ_TICKS);

    logic    ch_rst;
    logic    q_lock;
    gap_ev_t ev;

    assign ch_rst = rst | pd_i;

    lockdet_gap_meter u_meter (
        .clk   (clk),
        .rst   (ch_rst | clear_i),
        .ref_i (ref_i),
        .fb_i  (fb_i),
        .ev_o  (ev)
    );

    lockdet_qualifier #(
        .ACQ_TICKS (ACQ),
        .RUN_LEN   (RUN_LEN),
        .USE_DIV4  (KIND == KIND_RF)
    ) u_qual (
        .clk     (clk),
        .rst     (ch_rst),
        .clear_i (clear_i),
        .div4_i  (div4_i),
        .ev_i    (ev),
        .lock_o  (q_lock)
    );

    assign lock_o = q_lock & ~pd_i;

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import lockdet_pkg::*;
#(
    parameter int unsigned RF_ACQ_TICKS = 10,
    parameter int unsigned IF_ACQ_TICKS = 15,
    parameter int unsigned RUN_LEN      = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rf_ref_i,
    input  logic       rf_fb_i,
    input  logic       if_ref_i,
    input  logic       if_fb_i,
    input  logic       rf_pd_i,
    input  logic       if_pd_i,
    input  logic       rf_div4_i,
    input  logic       reinit_i,
    input  logic [1:0] view_i,
    output logic       lock_o
);

    localparam int unsigned NCH = 2;

    logic [NCH-1:0] ref_v, fb_v, pd_v, div_v, lock_v;
    view_e          view;

    assign ref_v = {if_ref_i, rf_ref_i};
    assign fb_v  = {if_fb_i,  rf_fb_i};
    assign pd_v  = {if_pd_i,  rf_pd_i};
    assign div_v = {1'b0,     rf_div4_i};
    assign view  = view_e'(view_i);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            lockdet_channel #(
                .KIND         ((i == 0) ? KIND_RF : KIND_IF),
                .RF_ACQ_TICKS (RF_ACQ_TICKS),
                .IF_ACQ_TICKS (IF_ACQ_TICKS),
                .RUN_LEN      (RUN_LEN)
            ) u_ch (
                .clk     (clk),
                .rst     (rst),
                .pd_i    (pd_v[i]),
                .clear_i (reinit_i),
                .div4_i  (div_v[i]),
                .ref_i   (ref_v[i]),
                .fb_i    (fb_v[i]),
                .lock_o  (lock_v[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (view)
            VIEW_RF: lock_o = lock_v[0];
            VIEW_IF: lock_o = lock_v[1];
            default: lock_o = &lock_v;
        endcase
    end

    // R7: a powered-down channel never shows lock
    p_pd_rf_low_r7: assert property (@(posedge clk) disable iff (rst)
        (rf_pd_i && view_i != 2'd1) |-> !lock_o);
    p_pd_if_low_r7: assert property (@(posedge clk) disable iff (rst)
        (if_pd_i && view_i != 2'd0) |-> !lock_o);

    // R8: combined view is low if either channel is unlocked
    p_both_and_r8: assert property (@(posedge clk) disable iff (rst)
        (view_i[1] && lock_v != 2'b11) |-> !lock_o);

    // R11: first cycle after reset release shows no lock
    p_reset_low_r11: assert property (@(posedge clk)
        $past(rst) |-> !lock_o);

endmodule

// File: tb/sim_pll_lock_monitor.sv
`timescale 1ns/100ps
module sim_pll_lock_monitor;

    localparam int PER = 64;
    localparam int REF_AT = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rf_ref = 0, rf_fb = 0, if_ref = 0, if_fb = 0;
    logic rf_pd = 0, if_pd = 0, div4 = 0, reinit = 0;
    logic [1:0] view = 2'd0;
    logic lock;

    int checks = 0;
    int errors = 0;

    // requirement model state, index 0 = first channel, 1 = second
    int  run  [2];
    bit  lk   [2];
    int  pre;
    bit  miss_prev [2];

    always #2 clk = ~clk;

    pll_lock_monitor u0 (
        .clk(clk), .rst(rst),
        .rf_ref_i(rf_ref), .rf_fb_i(rf_fb), .if_ref_i(if_ref), .if_fb_i(if_fb),
        .rf_pd_i(rf_pd), .if_pd_i(if_pd), .rf_div4_i(div4), .reinit_i(reinit),
        .view_i(view), .lock_o(lock)
    );

    function automatic int acq_of(int ch);
        return (ch == 0) ? 10 : 15;   // R3
    endfunction

    task automatic chk(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: lock_o=%0b expected %0b view=%0d t=%0t", req, got, exp, view, $time);
        end
    endtask

    task automatic m_clear(int ch);
        run[ch] = 0; lk[ch] = 0; miss_prev[ch] = 0;
        if (ch == 0) pre = 0;
    endtask

    task automatic m_event(int ch, bit paired, int gap);
        if (ch == 0 && div4) begin          // R6
            if (pre != 3) begin pre++; return; end
            pre = 0;
        end
        if (lk[ch]) begin
            if (!paired || gap > 2 * acq_of(ch)) begin lk[ch] = 0; run[ch] = 0; end   // R2
        end else if (paired && gap < acq_of(ch)) begin
            run[ch]++;
            if (run[ch] == 5) begin lk[ch] = 1; run[ch] = 0; end                      // R1
        end else begin
            run[ch] = 0;                                                              // R4
        end
    endtask

    task automatic m_period(int ch, bit miss, int g);
        if (miss_prev[ch]) m_event(ch, 0, 0);   // R5
        if (miss) miss_prev[ch] = 1;
        else begin miss_prev[ch] = 0; m_event(ch, 1, (g < 0) ? -g : g); end   // R10
    endtask

    task automatic check_views(string tag);
        bit e0, e1;
        e0 = lk[0] && !rf_pd;
        e1 = lk[1] && !if_pd;
        view = 2'd0; #0.4; chk({tag, " R8 view0"}, lock, e0);
        view = 2'd1; #0.4; chk({tag, " R8 view1"}, lock, e1);
        view = 2'd2; #0.4; chk({tag, " R8 view2"}, lock, e0 && e1);
        view = 2'd3; #0.4; chk({tag, " R8 view3"}, lock, e0 && e1);
    endtask

    // one comparison period on both channels
    task automatic period(string tag, int g_rf, int g_if, bit miss_rf, bit miss_if);
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            rf_ref = (c == REF_AT);
            if_ref = (c == REF_AT);
            rf_fb  = !miss_rf && (c == REF_AT + g_rf);
            if_fb  = !miss_if && (c == REF_AT + g_if);
        end
        @(negedge clk);
        rf_ref = 0; if_ref = 0; rf_fb = 0; if_fb = 0;
        if (!rf_pd) m_period(0, miss_rf, g_rf);
        if (!if_pd) m_period(1, miss_if, g_if);
        check_views(tag);
    endtask

    task automatic do_reinit();
        @(negedge clk); reinit = 1;
        @(negedge clk); reinit = 0;
        m_clear(0); m_clear(1);
    endtask

    task automatic set_pd(bit a, bit b);
        @(negedge clk); rf_pd = a; if_pd = b;
        if (a) m_clear(0);
        if (b) m_clear(1);
        @(negedge clk);
    endtask

    task automatic set_div4(bit v);
        @(negedge clk); div4 = v; pre = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        int g0, g1;
        bit m0;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_clear(0); m_clear(1);
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_views("R11 reset");

        // R1: four good periods are not enough, the fifth locks
        for (int k = 0; k < 4; k++) period("R1 run", 3, 3, 0, 0);
        period("R1 fifth", 3, 3, 0, 0);

        // R2/R3: hold window edges, inclusive at 20 and 30
        period("R2 R3 hold edge", 20, 30, 0, 0);
        period("R2 R3 hold over", 21, 31, 0, 0);

        // R4/R3: acquire boundary is strict
        for (int k = 0; k < 3; k++) period("R4 pre", 9, 14, 0, 0);
        period("R4 boundary", 10, 15, 0, 0);
        for (int k = 0; k < 4; k++) period("R4 rerun", 9, 14, 0, 0);
        period("R4 relock", 9, 14, 0, 0);

        // R9: re-initialise drops lock
        do_reinit();
        check_views("R9 reinit");

        // R10: feedback leading and equal-cycle edges
        for (int k = 0; k < 5; k++) period("R10 lead", -5, 0, 0, 0);

        // R5: missing feedback, failure shows at the next reference
        period("R5 miss", 2, 2, 1, 0);
        period("R5 after", 2, 2, 0, 0);

        // R6: quarter-rate evaluation on the first channel only
        do_reinit();
        set_div4(1);
        for (int k = 0; k < 20; k++) period("R6 div4", 2, 2, 0, 0);
        for (int k = 0; k < 3; k++) period("R6 skipped", 25, 2, 0, 0);
        period("R6 taken", 25, 2, 0, 0);
        set_div4(0);

        // R7: power-down forces low and clears
        for (int k = 0; k < 5; k++) period("R7 lock", 1, 1, 0, 0);
        set_pd(1, 0);
        period("R7 pd", 1, 1, 0, 0);
        set_pd(0, 1);
        period("R7 release", 1, 1, 0, 0);
        set_pd(0, 0);
        for (int k = 0; k < 4; k++) period("R7 rerun", 1, 1, 0, 0);

        // seeded random mix
        m0 = 0;
        for (int k = 0; k < 40; k++) begin
            bit mr;
            g0 = ($urandom % 4 == 0) ? int'($urandom % 50) - 20 : int'($urandom % 12);
            g1 = ($urandom % 4 == 0) ? int'($urandom % 50) - 20 : int'($urandom % 17);
            mr = !m0 && ($urandom % 10 == 0);
            if (m0 && g0 < 0) g0 = -g0;
            if (k % 13 == 12) do_reinit();
            if (k == 20) set_div4(1);
            if (k == 30) set_div4(0);
            period("R1 R2 R4 random", g0, g1, mr, 0);
            m0 = mr;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule